// File: doc/BRIEF.md
# Compare-Reset Sixteen-Bit Timer

This block is a 16-bit up-counter paired with one compare channel. The counter advances either on a qualifying internal tick strobe (timer mode) or on synchronized rising edges of an external input (synchronous counter mode). When it passes 0xFFFF it wraps to zero and latches an overflow flag. Software clears that flag. An interrupt request is the flag qualified by an enable bit.

The compare channel holds a 16-bit match value and a 4-bit mode code. With the code set to the special-event value, the match value becomes the timer period. When the counter reaches the match value and is due to advance, it returns to zero and emits a one-cycle event pulse. That pulse can also start an external converter. A reset caused this way never counts as an overflow. A software load of the counter in the same cycle takes precedence over it.

The counter is loaded through an 8-bit byte port. The upper byte is staged first. Writing the lower byte then commits both halves in a single edge, so software never sees a half-updated count.

Top module: `cmp_reset_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count`, `ovf_flag`, `irq`, `evt_trig` and `conv_start` become 0, and the match value and mode code are cleared to 0.
- R2: With `cnt_mode`=0, `count` increments by one at each edge where `run_en` and `tick_en` are both high, and holds otherwise.
- R3: With `cnt_mode`=1, `tick_en` is ignored. `count` increments once per rising edge of `ext_in`, at the third clock edge after `ext_in` is first sampled high. A steady level causes no further counting.
- R4: An advance from 0xFFFF to 0x0000 sets `ovf_flag`. The flag stays set until an edge with `ovf_clr` high. A wrap and a clear at the same edge leave the flag set.
- R5: `irq` is a register equal to the flag value latched at the same edge ANDed with `irq_en`.
- R6: `wr_hi` stores `wr_data` as the upper byte without changing `count`. `wr_lo` loads {stored upper byte, `wr_data`} into `count` at that edge.
- R7: With mode code 4'b1011, an advancing edge at which `count` equals the match value sets `count` to 0 and raises `evt_trig` for that one cycle.
- R8: In mode 4'b1011 with match value P, `count` cycles through 0..P, taking P+1 advances per period.
- R9: A special-event reset never sets `ovf_flag`, even when the match value is 0xFFFF.
- R10: When `wr_lo` coincides with a special-event reset, the written value is loaded. `evt_trig` still pulses.
- R11: `conv_start` pulses together with `evt_trig` only when `conv_en` was high at that edge.
- R12: With any mode code other than 4'b1011, a match neither resets `count` nor raises `evt_trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter run enable |
| cnt_mode | input | 1 | 0 = count tick strobes, 1 = count external edges |
| tick_en | input | 1 | Timer-mode advance strobe |
| ext_in | input | 1 | External count input, asynchronous |
| wr_hi | input | 1 | Stage upper count byte |
| wr_lo | input | 1 | Write lower count byte and commit full count |
| wr_data | input | 8 | Count write byte |
| cmp_we | input | 1 | Match value write strobe |
| cmp_wdata | input | 16 | Match value |
| mode_we | input | 1 | Mode code write strobe |
| mode_wdata | input | 4 | Compare mode code |
| ovf_clr | input | 1 | Clear overflow flag |
| irq_en | input | 1 | Interrupt enable |
| conv_en | input | 1 | Converter enable |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| evt_trig | output | 1 | Special-event pulse |
| conv_start | output | 1 | Converter start pulse |

## Verification
The assertions assume that the match value and mode code are rewritten only while `run_en` is low. They also assume `wr_hi` and `wr_lo` are never raised together. Under those conditions, a pulse on `evt_trig` without a coinciding byte load must leave `count` at zero. The directed tasks follow both assumptions: they stop the counter before reprogramming the channel, and they always stage the upper byte one cycle before committing the lower one. The stimulus also keeps `ext_in` at each level for at least three cycles, so that the synchronizer sees every transition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MODE_W  = 4;
  localparam logic [MODE_W-1:0] MODE_PERIOD_RST = 4'b1011;
  typedef enum logic {SRC_TICK = 1'b0, SRC_EXT = 1'b1} cnt_src_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // index STAGES holds the previous synchronized value for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  generate
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tmr_load_stage.sv
module tmr_load_stage #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_val
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0] hi_buf;

  always_ff @(posedge clk) begin
    if (rst)        hi_buf <= '0;
    else if (wr_hi) hi_buf <= wr_data[HI_W-1:0];
  end

  assign load_en  = wr_lo;
  assign load_val = {hi_buf, wr_data};
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MODE_W = 4,
  parameter logic [MODE_W-1:0] RST_CODE = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic              hit
);
  logic [CNT_W-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cmp_we)  cmp_q  <= cmp_wdata;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  assign hit = (mode_q == RST_CODE) && (cnt == cmp_q);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hit,
  input  logic             ovf_clr,
  input  logic             irq_en,
  input  logic             conv_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq,
  output logic             evt_trig,
  output logic             conv_start
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             evt_fire;
  logic             wrap;
  logic [CNT_W-1:0] cnt_nx;
  logic             flag_nx;

  always_comb begin
    evt_fire = hit && adv;
    wrap     = adv && (count == CNT_MAX) && !evt_fire && !load_en;
    if (load_en)       cnt_nx = load_val;
    else if (evt_fire) cnt_nx = '0;
    else if (adv)      cnt_nx = count + 1'b1;
    else               cnt_nx = count;
    if (wrap)          flag_nx = 1'b1;
    else if (ovf_clr)  flag_nx = 1'b0;
    else               flag_nx = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      ovf_flag   <= 1'b0;
      irq        <= 1'b0;
      evt_trig   <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      count      <= cnt_nx;
      ovf_flag   <= flag_nx;
      irq        <= flag_nx & irq_en;
      evt_trig   <= evt_fire;
      conv_start <= evt_fire & conv_en;
    end
  end
endmodule

// File: rtl/cmp_reset_timer.sv
module cmp_reset_timer #(
  parameter int unsigned CNT_W       = tmr_pkg::CNT_W,
  parameter int unsigned BYTE_W      = tmr_pkg::BYTE_W,
  parameter int unsigned MODE_W      = tmr_pkg::MODE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              cnt_mode,
  input  logic              tick_en,
  input  logic              ext_in,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              ovf_clr,
  input  logic              irq_en,
  input  logic              conv_en,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic              irq,
  output logic              evt_trig,
  output logic              conv_start
);
  import tmr_pkg::*;

  logic             ext_rise;
  logic             adv;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic             hit;
  cnt_src_e         src;

  assign src = cnt_src_e'(cnt_mode);
  assign adv = run_en && ((src == SRC_EXT) ? ext_rise : tick_en);

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .rise(ext_rise)
  );

  tmr_load_stage #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_load (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .load_en(load_en), .load_val(load_val)
  );

  tmr_match #(.CNT_W(CNT_W), .MODE_W(MODE_W), .RST_CODE(MODE_PERIOD_RST)) u_match (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt(count), .hit(hit)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .load_en(load_en), .load_val(load_val),
    .hit(hit), .ovf_clr(ovf_clr), .irq_en(irq_en), .conv_en(conv_en),
    .count(count), .ovf_flag(ovf_flag), .irq(irq),
    .evt_trig(evt_trig), .conv_start(conv_start)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             wr_lo,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             irq,
  input logic             evt_trig,
  input logic             conv_start
);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);

  // R11
  conv_with_evt_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> evt_trig);

  // R7
  evt_clears_chk: assert property (@(posedge clk) disable iff (rst)
    evt_trig && !$past(wr_lo) |-> count == '0);

  // R9
  ovf_from_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (count == '0) && ($past(count) == {CNT_W{1'b1}}));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en && !wr_lo |=> $stable(count));
endmodule

bind cmp_reset_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .wr_lo(wr_lo), .ovf_clr(ovf_clr),
  .count(count), .ovf_flag(ovf_flag), .irq(irq), .evt_trig(evt_trig),
  .conv_start(conv_start)
);

// File: tb/cmp_reset_timer_test.sv
module cmp_reset_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 0, cnt_mode = 0, tick_en = 0, ext_in = 0;
  logic        wr_hi = 0, wr_lo = 0;
  logic [7:0]  wr_data = '0;
  logic        cmp_we = 0, mode_we = 0;
  logic [15:0] cmp_wdata = '0;
  logic [3:0]  mode_wdata = '0;
  logic        ovf_clr = 0, irq_en = 0, conv_en = 0;
  logic [15:0] count;
  logic        ovf_flag, irq, evt_trig, conv_start;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  cmp_reset_timer uut (
    .clk(clk), .rst(rst), .run_en(run_en), .cnt_mode(cnt_mode), .tick_en(tick_en),
    .ext_in(ext_in), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ovf_clr(ovf_clr), .irq_en(irq_en), .conv_en(conv_en), .count(count),
    .ovf_flag(ovf_flag), .irq(irq), .evt_trig(evt_trig), .conv_start(conv_start)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load16(logic [15:0] v);
    wr_hi = 1; wr_data = v[15:8]; step(1); wr_hi = 0;
    wr_lo = 1; wr_data = v[7:0];  step(1); wr_lo = 0;
  endtask

  task automatic program_cmp(logic [15:0] p, logic [3:0] m);
    cmp_we = 1; cmp_wdata = p; mode_we = 1; mode_wdata = m;
    step(1); cmp_we = 0; mode_we = 0;
  endtask

  task automatic t_reset;
    rst = 1; step(2); rst = 0;
    chk("R1", "count", count, 0);
    chk("R1", "ovf_flag", ovf_flag, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "evt_trig", evt_trig, 0);
    chk("R1", "conv_start", conv_start, 0);
  endtask

  task automatic t_timer;
    run_en = 1; tick_en = 1; step(5);
    chk("R2", "count after 5 ticks", count, 5);
    tick_en = 0; step(3);
    chk("R2", "hold without tick", count, 5);
    for (int i = 0; i < 4; i++) begin tick_en = (i % 2 == 0); step(1); end
    chk("R2", "alternating ticks", count, 7);
    run_en = 0; tick_en = 1; step(2); tick_en = 0;
    chk("R2", "hold with run_en low", count, 7);
  endtask

  task automatic t_write;
    wr_hi = 1; wr_data = 8'h12; step(1); wr_hi = 0;
    chk("R6", "wr_hi alone", count, 7);
    wr_lo = 1; wr_data = 8'h34; step(1); wr_lo = 0;
    chk("R6", "commit", count, 16'h1234);
  endtask

  task automatic t_wrap;
    load16(16'hFFFD);
    run_en = 1; tick_en = 1; step(3); tick_en = 0;
    chk("R4", "wrapped count", count, 0);
    chk("R4", "flag set", ovf_flag, 1);
    chk("R5", "irq masked", irq, 0);
    irq_en = 1; step(1);
    chk("R5", "irq enabled", irq, 1);
    step(2);
    chk("R4", "flag sticky", ovf_flag, 1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    chk("R4", "flag cleared", ovf_flag, 0);
    chk("R5", "irq follows clear", irq, 0);
    run_en = 0; load16(16'hFFFF); run_en = 1;
    tick_en = 1; ovf_clr = 1; step(1); tick_en = 0; ovf_clr = 0;
    chk("R4", "set wins over clear", ovf_flag, 1);
    ovf_clr = 1; irq_en = 0; step(1); ovf_clr = 0; run_en = 0;
  endtask

  task automatic t_period;
    program_cmp(16'd3, 4'b1011);
    load16(16'h0000);
    run_en = 1; tick_en = 1;
    step(1); chk("R8", "seq 1", count, 1);
    step(1); chk("R8", "seq 2", count, 2);
    step(1); chk("R8", "seq 3", count, 3);
    chk("R7", "no evt before match", evt_trig, 0);
    step(1); chk("R7", "reset at match", count, 0);
    chk("R7", "evt pulse", evt_trig, 1);
    chk("R11", "conv blocked", conv_start, 0);
    step(1); chk("R8", "restart", count, 1);
    chk("R7", "evt one cycle", evt_trig, 0);
    step(2); conv_en = 1; step(1);
    chk("R11", "conv fires", conv_start, 1);
    chk("R9", "no overflow from event", ovf_flag, 0);
    step(1); conv_en = 0;
    chk("R11", "conv one cycle", conv_start, 0);
    run_en = 0; tick_en = 0;
  endtask

  task automatic t_max_event;
    program_cmp(16'hFFFF, 4'b1011);
    load16(16'hFFFE);
    run_en = 1; tick_en = 1; step(2); tick_en = 0; run_en = 0;
    chk("R9", "count reset at FFFF", count, 0);
    chk("R9", "evt at FFFF", evt_trig, 1);
    chk("R9", "no flag", ovf_flag, 0);
  endtask

  task automatic t_write_wins;
    program_cmp(16'd5, 4'b1011);
    load16(16'h0005);
    wr_hi = 1; wr_data = 8'h00; step(1); wr_hi = 0;
    run_en = 1; tick_en = 1; wr_lo = 1; wr_data = 8'h40; step(1);
    wr_lo = 0; tick_en = 0; run_en = 0;
    chk("R10", "write value kept", count, 16'h0040);
    chk("R10", "evt still pulses", evt_trig, 1);
  endtask

  task automatic t_other_mode;
    program_cmp(16'd2, 4'b1010);
    load16(16'h0001);
    run_en = 1; tick_en = 1;
    step(1); chk("R12", "at match", count, 2);
    step(1); chk("R12", "no reset", count, 3);
    chk("R12", "no evt", evt_trig, 0);
    run_en = 0; tick_en = 0;
    program_cmp(16'd0, 4'b0000);
  endtask

  task automatic t_counter_mode;
    load16(16'h0000);
    cnt_mode = 1; run_en = 1; tick_en = 1;
    ext_in = 1; step(2);
    chk("R3", "not yet counted", count, 0);
    step(1); chk("R3", "first edge counted", count, 1);
    step(3); chk("R3", "level ignored", count, 1);
    ext_in = 0; step(3); ext_in = 1; step(3);
    chk("R3", "second edge", count, 2);
    ext_in = 0; step(3);
    run_en = 0; cnt_mode = 0; tick_en = 0;
  endtask

  initial begin
    step(1);
    t_reset();
    t_timer();
    t_write();
    t_wrap();
    t_period();
    t_max_event();
    t_write_wins();
    t_other_mode();
    t_counter_mode();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule